// File: doc/BRIEF.md
# Dithered One-Bit Oversampling Estimator

This block turns the stream of decisions from a one-bit comparator into a multi-bit voltage estimate in millivolts. Ahead of the comparator, uniform random dither of known total span is added to the analog input. Averaged over many samples, the share of samples that come out 1 therefore tracks where the input sits inside the dither box. The block counts the 1 samples over a window of fixed length. From that count it works out the top edge of the dither box: the comparator threshold plus the fraction of ones times the span. It then removes half the span to land on the centre of the box, which is the input estimate.

A conversion begins with a one-cycle start pulse. The comparator bit is taken only on cycles where the sample strobe is high. When the window is full, the estimate is registered and a one-cycle valid pulse is raised. The window length is a power of two, so the division by the sample total is a shift. The product of the count and the span is formed before that shift, so small counts still add to the result.

Top module: `dither_estimator`

## Requirements
- R1: While reset is high and in the cycle after it, `est_mv` is 0 and `est_valid` is 0.
- R2: A comparator bit counts only on a cycle where `smp_stb` is high during a conversion. Strobes that arrive while no conversion runs are ignored. A strobe in the same cycle as `start` is also ignored.
- R3: A window holds exactly 2^WIN_LOG2 strobed samples (64 by default). `est_valid` goes high in the clock cycle that follows the clock edge that captured the last sample.
- R4: The estimate is THRESH_MV + floor(N1 × SPAN_MV / 2^WIN_LOG2) − SPAN_MV/2, where N1 is the number of 1 samples in the window. With the defaults (500 mV, 500 mV, 64), N1=16 gives 375 and N1=11 gives 335.
- R5: The extreme counts map to the box edges. N1=0 gives THRESH_MV − SPAN_MV/2 (250 by default) and N1=64 gives THRESH_MV + SPAN_MV/2 (750 by default).
- R6: `est_valid` lasts exactly one cycle. `est_mv` keeps its value until the next completed window replaces it, including while a new window is being collected.
- R7: A `start` during a conversion discards the samples gathered so far and opens a new full window. The aborted window produces no valid pulse.
- R8: The multiply comes before the shift, so one 1 sample in the window still raises the estimate: N1=1 gives 257 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that opens a new window |
| smp_stb | input | 1 | High on cycles that carry a comparator sample |
| smp_bit | input | 1 | Comparator decision (1 = above threshold) |
| est_mv | output | EST_W | Voltage estimate in millivolts, held |
| est_valid | output | 1 | One-cycle pulse when a new estimate is ready |

## Verification
The bench aims at off-by-one window handling. A design that closed the window one sample early or one sample late would report a count that is off by one sample and would pulse valid at the wrong cycle. It tests the extreme counts 0, 1 and 64. Shifting before multiplying would make N1=1 report 250, and a count register that is too narrow would wrap at 64 and report 250 instead of 750. It sends strobes while the block is idle, sends a strobe in the same cycle as start, and restarts in the middle of a window. A design that let stale samples leak into the count would return an estimate that differs from the queued one, or would raise a valid pulse with no estimate waiting in the queue.

// File: rtl/est_pkg.sv
package est_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } est_state_e;
endpackage

// File: rtl/est_window_counter.sv
module est_window_counter
  import est_pkg::*;
#(
  parameter int WIN_LOG2 = 6,
  localparam int ONES_W  = WIN_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              smp_stb,
  input  logic              smp_bit,
  output logic              last_hit,
  output logic [ONES_W-1:0] ones_final
);
  localparam logic [WIN_LOG2-1:0] IDX_LAST = {WIN_LOG2{1'b1}};

  est_state_e          state;
  logic [WIN_LOG2-1:0] idx;
  logic [ONES_W-1:0]   ones;
  logic                take;

  assign take       = (state == ST_RUN) && smp_stb && !start;
  assign last_hit   = take && (idx == IDX_LAST);
  assign ones_final = ones + ONES_W'(smp_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
      ones  <= '0;
    end else if (start) begin
      state <= ST_RUN;
      idx   <= '0;
      ones  <= '0;
    end else if (take) begin
      ones <= ones_final;
      idx  <= idx + 1'b1;
      if (idx == IDX_LAST) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/est_scaler.sv
module est_scaler #(
  parameter int WIN_LOG2  = 6,
  parameter int THRESH_MV = 500,
  parameter int SPAN_MV   = 500,
  parameter int EST_W     = 16,
  localparam int ONES_W   = WIN_LOG2 + 1,
  localparam int SPAN_W   = $clog2(SPAN_MV + 1),
  localparam int PROD_W   = ONES_W + SPAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              last_hit,
  input  logic [ONES_W-1:0] ones_final,
  output logic [EST_W-1:0]  est_mv,
  output logic              est_valid
);
  localparam int HALF_MV = SPAN_MV / 2;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] frac;
  logic [EST_W-1:0]  est_next;

  assign prod     = PROD_W'(ones_final) * PROD_W'(SPAN_MV);
  assign frac     = prod >> WIN_LOG2;
  assign est_next = EST_W'(THRESH_MV) + EST_W'(frac) - EST_W'(HALF_MV);

  always_ff @(posedge clk) begin
    if (rst) begin
      est_mv    <= '0;
      est_valid <= 1'b0;
    end else begin
      est_valid <= last_hit;
      if (last_hit) est_mv <= est_next;
    end
  end
endmodule

// File: rtl/dither_estimator.sv
module dither_estimator #(
  parameter int WIN_LOG2  = 6,
  parameter int THRESH_MV = 500,
  parameter int SPAN_MV   = 500,
  parameter int EST_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             smp_stb,
  input  logic             smp_bit,
  output logic [EST_W-1:0] est_mv,
  output logic             est_valid
);
  localparam int ONES_W = WIN_LOG2 + 1;

  logic              last_hit;
  logic [ONES_W-1:0] ones_final;

  est_window_counter #(.WIN_LOG2(WIN_LOG2)) u_count (
    .clk(clk), .rst(rst), .start(start), .smp_stb(smp_stb), .smp_bit(smp_bit),
    .last_hit(last_hit), .ones_final(ones_final)
  );

  est_scaler #(
    .WIN_LOG2(WIN_LOG2), .THRESH_MV(THRESH_MV), .SPAN_MV(SPAN_MV), .EST_W(EST_W)
  ) u_scale (
    .clk(clk), .rst(rst), .last_hit(last_hit), .ones_final(ones_final),
    .est_mv(est_mv), .est_valid(est_valid)
  );
endmodule

// File: rtl/est_checker.sv
module est_checker #(
  parameter int THRESH_MV = 500,
  parameter int SPAN_MV   = 500,
  parameter int EST_W     = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [EST_W-1:0] est_mv,
  input logic             est_valid
);
  localparam int LO_MV = THRESH_MV - SPAN_MV / 2;
  localparam int HI_MV = THRESH_MV + SPAN_MV / 2;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!est_valid && est_mv == '0)); // R1
  AST_NO_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst) start |=> !est_valid); // R7
  AST_EST_IN_BOX: assert property (@(posedge clk) disable iff (rst)
    est_valid |-> (int'(est_mv) >= LO_MV && int'(est_mv) <= HI_MV)); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) est_valid |=> !est_valid); // R6
  AST_EST_HOLD: assert property (@(posedge clk) disable iff (rst) !est_valid |-> $stable(est_mv)); // R6
endmodule

bind dither_estimator est_checker #(
  .THRESH_MV(THRESH_MV), .SPAN_MV(SPAN_MV), .EST_W(EST_W)
) u_est_chk (
  .clk(clk), .rst(rst), .start(start), .est_mv(est_mv), .est_valid(est_valid)
);

// File: tb/test_dither_estimator.sv
`timescale 1ns/1ps
module test_dither_estimator;
  localparam int WIN = 64;
  localparam int THR = 500;
  localparam int SPN = 500;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        smp_stb = 1'b0;
  logic        smp_bit = 1'b0;
  logic [15:0] est_mv;
  logic        est_valid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int exp_q[$];

  always #4 clk = ~clk;

  dither_estimator i_dither_estimator (
    .clk(clk), .rst(rst), .start(start), .smp_stb(smp_stb), .smp_bit(smp_bit),
    .est_mv(est_mv), .est_valid(est_valid)
  );

  function automatic int expect_mv(int n1);
    return THR + (n1 * SPN) / WIN - SPN / 2;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(bit with_stb);
    @(negedge clk);
    start = 1'b1; smp_stb = with_stb; smp_bit = 1'b1;
    @(negedge clk);
    start = 1'b0; smp_stb = 1'b0;
  endtask

  task automatic send_sample(bit b, int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    smp_stb = 1'b1; smp_bit = b;
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  // mode 0: ones first, mode 1: ones last, mode 2: ones first with gaps
  task automatic run_window(int n1, int mode, string req);
    exp_q.push_back(expect_mv(n1));
    for (int i = 0; i < WIN; i++) begin
      bit b = (mode == 1) ? (i >= WIN - n1) : (i < n1);
      int g = (mode == 2) ? (i % 3) : 0;
      if (i == WIN - 1) begin
        repeat (g) @(negedge clk);
        @(negedge clk);
        smp_stb = 1'b1; smp_bit = b;
        @(negedge clk);
        smp_stb = 1'b0;
        check({req, "/R3 valid after last sample"}, int'(est_valid), 1);
        @(negedge clk);
        check({req, "/R6 valid one cycle"}, int'(est_valid), 0);
      end else begin
        if (i == WIN - 2) check({req, "/R3 no early valid"}, int'(est_valid), 0);
        send_sample(b, g);
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && est_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected valid actual=%0d expected=none", est_mv);
      end else begin
        check("R4 estimate", int'(est_mv), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset est", int'(est_mv), 0);
    check("R1 reset valid", int'(est_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset valid", int'(est_valid), 0);

    // R2: idle strobes and a strobe on the start cycle are ignored
    for (int i = 0; i < 5; i++) send_sample(1'b1, 0);
    check("R2 idle strobes no valid", int'(est_valid), 0);
    pulse_start(1'b1);
    run_window(16, 0, "R2");            // expect 375
    check("R4 n1=16 value", int'(est_mv), 375);

    pulse_start(1'b0);
    run_window(11, 1, "R4");            // expect 335
    check("R4 n1=11 value", int'(est_mv), 335);

    pulse_start(1'b0);
    run_window(0, 0, "R5");
    check("R5 n1=0 value", int'(est_mv), 250);

    pulse_start(1'b0);
    run_window(64, 2, "R5");
    check("R5 n1=64 value", int'(est_mv), 750);

    // R6: estimate held during next window
    pulse_start(1'b0);
    for (int i = 0; i < 10; i++) send_sample(1'b0, 0);
    check("R6 hold during window", int'(est_mv), 750);
    // R7: restart mid-window, aborted samples discarded
    for (int i = 0; i < 20; i++) send_sample(1'b1, 0);
    pulse_start(1'b0);
    run_window(1, 1, "R8");
    check("R8 n1=1 value", int'(est_mv), 257);
    check("R7 restart result", int'(est_mv), expect_mv(1));

    // strobes after window end are ignored
    for (int i = 0; i < 4; i++) send_sample(1'b1, 0);
    repeat (2) @(negedge clk);
    check("R2 post-window strobes no change", int'(est_mv), 257);
    check("R4 scoreboard drained", exp_q.size(), 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule